// File: doc/BRIEF.md
# Byte Bit-Manipulation Unit

This unit works on a single bit inside one byte of memory. It can set the bit, clear it, invert it, or only test it. A command gives the operation, the addressing form and the operands. The unit reads the byte over a request/acknowledge memory port and records whether the chosen bit was zero before any change. For every operation except test, it then writes the modified byte back to the same address. When the operation ends, a one-cycle completion pulse marks the new value of the zero flag.

The byte address can be formed in two ways. In the offset form, it is a base register value plus a sign-extended 16-bit offset, and the bit number comes from a 3-bit immediate. In the register form, the base register value is the address with no offset, and the bit number is the low three bits of a second register value. The unit takes a new command only while it is idle. The zero flag is the only flag it changes, and it holds that flag steady between completions.

Top module: `bbm_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `mem_req`, `mem_we`, `done` and `flag_z` are all 0.
- R2: When `cmd_form` is 0 (offset form), the byte address is `cmd_base` plus `cmd_disp` sign-extended from 16 bits, with 32-bit wraparound, and the bit number is `cmd_imm_bit`.
- R3: When `cmd_form` is 1 (register form), the byte address is `cmd_base` with no offset, and the bit number is `cmd_bitreg[2:0]`. Bits 31:3 of `cmd_bitreg` have no effect.
- R4: At completion, `flag_z` is 1 exactly when the selected bit of the byte read from memory was 0 before modification.
- R5: Op code 0 (set) writes back the read byte ORed with the bit mask, to the same address that was read.
- R6: Op code 2 (clear) writes back the read byte ANDed with the inverted bit mask, to the same address.
- R7: Op code 1 (invert) writes back the read byte XORed with the bit mask, to the same address.
- R8: Op code 3 (test) performs the read and the flag update but issues no write, and the memory byte is left unchanged.
- R9: `done` is high for exactly one cycle per command. `flag_z` changes only in a cycle in which `done` is high.
- R10: A command is accepted only while `cmd_ready` is 1. A `cmd_valid` asserted while the unit is busy causes no extra memory access and changes no memory.
- R11: Once `mem_req` rises, it stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle; command accepted when valid |
| cmd_op | input | 2 | 0 set, 1 invert, 2 clear, 3 test |
| cmd_form | input | 1 | 0 offset form, 1 register form |
| cmd_base | input | 32 | Base register value |
| cmd_disp | input | 16 | Signed offset (offset form) |
| cmd_imm_bit | input | 3 | Bit number (offset form) |
| cmd_bitreg | input | 32 | Bit-number register value (register form) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 8 | Read byte |
| flag_z | output | 1 | Zero flag: selected bit was 0 |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each operation is applied to bytes in which the selected bit is first 1 and then 0. This separates the flag polarity and each mask operation from a plain rewrite of the byte that was read. Offsets are used with both signs, which exposes a zero-extended offset. Register-form commands carry junk in the high bits of the bit register, which exposes decoding that uses more than three bits. The memory model varies its acknowledge latency from zero to three cycles, and a stray command is presented mid-operation; these show whether the handshake holds and whether the idle-only acceptance rule is kept.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_INV = 2'd1,
    OP_CLR = 2'd2,
    OP_TST = 2'd3
  } bbm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_MODIFY  = 3'd3,
    ST_WRITE   = 3'd4,
    ST_WR_WAIT = 3'd5,
    ST_DONE    = 3'd6
  } bbm_state_e;
endpackage

// File: rtl/bbm_ea.sv
module bbm_ea #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              form_reg,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic [BIT_W-1:0]  imm_bit,
  input  logic [ADDR_W-1:0] bitreg,
  output logic [ADDR_W-1:0] addr,
  output logic [BIT_W-1:0]  bitsel
);
  logic [ADDR_W-1:0] disp_sx;

  assign disp_sx = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

  always_comb begin
    if (form_reg) begin
      addr   = base;
      bitsel = bitreg[BIT_W-1:0];
    end else begin
      addr   = base + disp_sx;
      bitsel = imm_bit;
    end
  end
endmodule

// File: rtl/bbm_modify.sv
module bbm_modify
  import bbm_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  bbm_op_e           op,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [BIT_W-1:0]  bitsel,
  output logic [DATA_W-1:0] byte_out,
  output logic              zero
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (bitsel == BIT_W'(i));
  end

  assign zero = ~|(byte_in & mask);

  always_comb begin
    unique case (op)
      OP_SET:  byte_out = byte_in | mask;
      OP_INV:  byte_out = byte_in ^ mask;
      OP_CLR:  byte_out = byte_in & ~mask;
      default: byte_out = byte_in;
    endcase
  end
endmodule

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid,
  input  logic is_test,
  input  logic mem_ack,
  output logic cmd_ready,
  output logic accept,
  output logic capture,
  output logic load_wdata,
  output logic finish,
  output logic mem_req,
  output logic mem_we,
  output logic done
);
  bbm_state_e state;

  assign cmd_ready  = (state == ST_IDLE);
  assign accept     = cmd_ready && cmd_valid;
  assign capture    = (state == ST_RD_WAIT) && mem_ack;
  assign load_wdata = (state == ST_MODIFY);
  assign finish     = ((state == ST_MODIFY) && is_test) ||
                      ((state == ST_WR_WAIT) && mem_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      unique case (state)
        ST_IDLE:    if (cmd_valid) state <= ST_READ;
        ST_READ: begin
          mem_req <= 1'b1;
          mem_we  <= 1'b0;
          state   <= ST_RD_WAIT;
        end
        ST_RD_WAIT: if (mem_ack) begin
          mem_req <= 1'b0;
          state   <= ST_MODIFY;
        end
        ST_MODIFY:  state <= is_test ? ST_DONE : ST_WRITE;
        ST_WRITE: begin
          mem_req <= 1'b1;
          mem_we  <= 1'b1;
          state   <= ST_WR_WAIT;
        end
        ST_WR_WAIT: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state   <= ST_DONE;
        end
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mem_req);
  assert_we_with_req_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

// File: rtl/bbm_unit.sv
module bbm_unit
  import bbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_form,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [DISP_W-1:0] cmd_disp,
  input  logic [BIT_W-1:0]  cmd_imm_bit,
  input  logic [ADDR_W-1:0] cmd_bitreg,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              flag_z,
  output logic              done
);
  logic [ADDR_W-1:0] ea_addr;
  logic [BIT_W-1:0]  ea_bit;
  logic [BIT_W-1:0]  bit_q;
  bbm_op_e           op_q;
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] mod_byte;
  logic              mod_zero;
  logic              accept, capture, load_wdata, finish;

  bbm_ea #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .DATA_W(DATA_W)) u_ea (
    .form_reg (cmd_form),
    .base     (cmd_base),
    .disp     (cmd_disp),
    .imm_bit  (cmd_imm_bit),
    .bitreg   (cmd_bitreg),
    .addr     (ea_addr),
    .bitsel   (ea_bit)
  );

  bbm_modify #(.DATA_W(DATA_W)) u_mod (
    .op       (op_q),
    .byte_in  (byte_q),
    .bitsel   (bit_q),
    .byte_out (mod_byte),
    .zero     (mod_zero)
  );

  bbm_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .is_test    (op_q == OP_TST),
    .mem_ack    (mem_ack),
    .cmd_ready  (cmd_ready),
    .accept     (accept),
    .capture    (capture),
    .load_wdata (load_wdata),
    .finish     (finish),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      bit_q     <= '0;
      op_q      <= OP_SET;
      byte_q    <= '0;
      flag_z    <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= ea_addr;
        bit_q    <= ea_bit;
        op_q     <= bbm_op_e'(cmd_op);
      end
      if (capture)    byte_q    <= mem_rdata;
      if (load_wdata) mem_wdata <= mod_byte;
      if (finish)     flag_z    <= mod_zero;
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_flag_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(flag_z) |-> done);
  assert_test_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_TST) |-> !mem_we);
endmodule

// File: tb/bbm_unit_bench.sv
`timescale 1ns/1ps
module bbm_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic        cmd_form = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_disp = '0;
  logic [2:0]  cmd_imm_bit = '0;
  logic [31:0] cmd_bitreg = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack;
  logic [7:0]  mem_rdata;
  logic        flag_z, done;

  always #5 clk = ~clk;

  bbm_unit u_bbm_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_form(cmd_form), .cmd_base(cmd_base),
    .cmd_disp(cmd_disp), .cmd_imm_bit(cmd_imm_bit), .cmd_bitreg(cmd_bitreg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .flag_z(flag_z), .done(done)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model
  logic [7:0]  mem [256];
  int          lat = 0;
  int          cnt;
  int          reads, writes;
  logic [31:0] last_rd_addr, last_wr_addr, req_addr;
  logic        req_open;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
      mem_ack <= 1'b0; mem_rdata <= '0; cnt <= 0;
      reads <= 0; writes <= 0; req_open <= 1'b0;
      last_rd_addr <= '0; last_wr_addr <= '0; req_addr <= '0;
    end else if (mem_req && !mem_ack) begin
      if (!req_open) begin req_open <= 1'b1; req_addr <= mem_addr; end
      else chk(mem_addr == req_addr, "R11", "address moved during request",
               mem_addr, req_addr);
      if (cnt >= lat) begin
        mem_ack <= 1'b1; cnt <= 0; req_open <= 1'b0;
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          writes <= writes + 1; last_wr_addr <= mem_addr;
        end else begin
          mem_rdata <= mem[mem_addr[7:0]];
          reads <= reads + 1; last_rd_addr <= mem_addr;
        end
      end else cnt <= cnt + 1;
    end else mem_ack <= 1'b0;
  end

  // scoreboard
  typedef struct {
    logic [31:0] addr;
    logic        z;
    logic [7:0]  nbyte;
    int          wr;
  } exp_t;
  exp_t        q[$];
  logic [7:0]  shadow [256];
  int          cmds = 0;
  int          wr_snap = 0;
  logic        prev_done = 1'b0;

  initial for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 37 + 5);

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) chk(!done, "R9", "done longer than one cycle", 32'(done), 0);
      if (done) begin
        if (q.size() == 0) chk(0, "R10", "unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(flag_z == e.z, "R4", "zero flag", 32'(flag_z), 32'(e.z));
          chk(last_rd_addr == e.addr, "R2/R3", "read address", last_rd_addr, e.addr);
          chk(mem[e.addr[7:0]] == e.nbyte, "R5/R6/R7/R8", "memory byte",
              32'(mem[e.addr[7:0]]), 32'(e.nbyte));
          chk(writes - wr_snap == e.wr, "R8", "write count", writes - wr_snap, e.wr);
          if (e.wr == 1)
            chk(last_wr_addr == e.addr, "R5", "write address", last_wr_addr, e.addr);
          wr_snap = writes;
        end
      end
      prev_done = done;
    end
  end

  task automatic issue(input bit form, input logic [1:0] op, input logic [31:0] base,
                       input logic [15:0] disp, input logic [2:0] imm,
                       input logic [31:0] breg);
    exp_t e;
    logic [2:0] b;
    logic [7:0] orig, m;
    b = form ? breg[2:0] : imm;
    e.addr = form ? base : base + {{16{disp[15]}}, disp};
    orig = shadow[e.addr[7:0]];
    m = 8'(1) << b;
    e.z = ((orig & m) == 0);
    case (op)
      2'd0: e.nbyte = orig | m;
      2'd1: e.nbyte = orig ^ m;
      2'd2: e.nbyte = orig & ~m;
      default: e.nbyte = orig;
    endcase
    e.wr = (op == 2'd3) ? 0 : 1;
    shadow[e.addr[7:0]] = e.nbyte;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_form = form; cmd_op = op; cmd_base = base;
    cmd_disp = disp; cmd_imm_bit = imm; cmd_bitreg = breg;
    q.push_back(e);
    cmds++;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || !cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", 32'(cmd_ready), 1);
    chk(!mem_req && !mem_we, "R1", "mem_req/mem_we", 32'({mem_req, mem_we}), 0);
    chk(!done && !flag_z, "R1", "done/flag_z", 32'({done, flag_z}), 0);

    // R2 R5: offset form, positive offset, set
    issue(0, 2'd0, 32'h1000_0020, 16'h0011, 3'd6, 32'h0);
    // R2 R6: negative offset, clear
    issue(0, 2'd2, 32'h1000_0080, 16'hFFF0, 3'd0, 32'h0);
    // R3 R7: register form, junk in high bits, invert
    issue(1, 2'd1, 32'h0000_0042, 16'h7FFF, 3'd0, 32'hFFFF_FFF9);
    // R8: test in both forms
    issue(1, 2'd3, 32'h0000_0042, 16'h0, 3'd0, 32'h0000_0101);
    issue(0, 2'd3, 32'h0000_0040, 16'h0002, 3'd3, 32'h0);
    // R5/R6 no-change cases: set a set bit, clear a clear bit
    issue(0, 2'd0, 32'h1000_0020, 16'h0011, 3'd6, 32'h0);
    issue(0, 2'd2, 32'h1000_0080, 16'hFFF0, 3'd0, 32'h0);
    drain();

    // R9 flag holds while idle
    begin
      logic fz;
      fz = flag_z;
      repeat (6) @(negedge clk);
      chk(flag_z == fz, "R9", "flag held while idle", 32'(flag_z), 32'(fz));
    end

    // R10 stray command during a busy operation
    lat = 3;
    issue(1, 2'd1, 32'h0000_0090, 16'h0, 3'd0, 32'h4);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_form = 1'b1; cmd_op = 2'd0;
    cmd_base = 32'h0000_00A0; cmd_bitreg = 32'h7;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    drain();
    chk(mem[8'hA0] == shadow[8'hA0], "R10", "stray target untouched",
        32'(mem[8'hA0]), 32'(shadow[8'hA0]));

    // R4 R7 sweep of bits and latencies
    for (int k = 0; k < 16; k++) begin
      lat = k % 4;
      issue(1, 2'(k % 4), 32'h0000_0033, 16'h0, 3'd0, 32'(k * 5) | 32'hABC0_0000);
    end
    drain();
    chk(reads == cmds, "R10", "read count", reads, cmds);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule